// File: doc/BRIEF.md
# Byte-Masked Synchronous RAM

A single-port synchronous memory whose write path can store only selected lanes of the input word. A write takes place on a rising clock edge when the write strobe is high. Within that write, each set bit of the lane-enable vector lets its lane of the write data into the addressed word. Every lane whose bit is clear keeps the value it held before.

The word width is a parameter and must be 16, 18, 32 or 36 bits. The 16- and 32-bit widths use 8-bit lanes. The 18- and 36-bit widths use 9-bit lanes, so the extra bit of each lane is masked along with it. Any other width stops elaboration.

The read port is registered. On a write cycle it returns the merged word, which carries the new data in the enabled lanes and the old data in the others. On a read-only cycle it returns the stored word. On an idle cycle it holds its last value. A parameter fills every location with all-ones at start-up, so that masked writes land on a known background.

Top module: `bmask_ram`

## Requirements
- R1: When we_i is low, the array is not modified, whatever be_i, wdata_i and re_i are.
- R2: On a write (we_i high), each lane whose be_i bit is 1 is replaced by the matching lane of wdata_i. Each lane whose bit is 0 keeps its previous content.
- R3: be_i bit k controls lane k. Lane k spans bits [k*LW+LW-1 : k*LW], so bit 0 selects the least significant lane.
- R4: LW is 9 when DATA_W is 18 or 36 and 8 when DATA_W is 16 or 32. Widths outside {16, 18, 32, 36} fail elaboration.
- R5: A write with be_i all zeros leaves the word unchanged and returns the unchanged stored word on rdata_o.
- R6: One cycle after a write edge, rdata_o holds the merged word. For example, writing 0xABCD over 0xFFFF gives 0xABFF with be_i=2'b10, 0xFFCD with 2'b01 and 0xABCD with 2'b11.
- R7: After an edge with re_i high and we_i low, rdata_o holds the word stored at addr_i.
- R8: After an edge with both re_i and we_i low, rdata_o is unchanged.
- R9: While rst_ni is low, rdata_o is all zeros. Reset does not alter the array contents.
- R10: With INIT_ONES set, every location reads as all-ones before it is first written.
- R11: When we_i and re_i are both high, the write takes place and rdata_o shows the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the read register |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | LANES | Lane enables, active high, bit 0 = lowest lane |
| rdata_o | output | DATA_W | Registered read data |

## Verification
A read and a write can fall in the same cycle. They are provoked together by holding re_i and we_i high on the same edge, with a partial lane mask and a word whose old content differs from the new data. The result is judged in two ways. First, rdata_o must carry the merged word and not the old word. Second, a later read-only cycle to the same address must return that same merged word, which shows that the write took effect and that the unmasked lanes stayed intact. Both 8-bit and 9-bit lane widths are driven side by side so that lane boundaries are checked for each layout.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  function automatic int lane_width(int dw);
    return (dw % 9 == 0) ? 9 : 8;
  endfunction

  function automatic bit width_ok(int dw);
    return (dw == 16) || (dw == 18) || (dw == 32) || (dw == 36);
  endfunction
endpackage

// File: rtl/bmr_array.sv
module bmr_array #(
  parameter int ADDR_W    = 6,
  parameter int LANE_W    = 8,
  parameter int LANES     = 4,
  parameter bit INIT_ONES = 1'b1,
  localparam int DATA_W   = LANE_W * LANES,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rword_o
);
  // one storage column per lane, written independently
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    initial begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] = INIT_ONES ? '1 : '0;
    end

    always_ff @(posedge clk_i) begin
      if (lane_we_i[l]) mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rword_o[l*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/bmr_merge.sv
module bmr_merge #(
  parameter int LANE_W  = 8,
  parameter int LANES   = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [LANES-1:0]  sel_i,
  output logic [DATA_W-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*LANE_W +: LANE_W] = sel_i[l] ? new_i[l*LANE_W +: LANE_W]
                                                   : old_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/bmr_rd_reg.sv
module bmr_rd_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] merged_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q;

  // write has priority: output shows what the array now holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (we_i) rdata_q <= merged_i;
    else if (re_i) rdata_q <= old_i;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bmask_ram.sv
module bmask_ram
  import bmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter bit INIT_ONES = 1'b1,
  localparam int LANE_W   = lane_width(DATA_W),
  localparam int LANES    = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] rdata_o
);
  if (!width_ok(DATA_W)) begin : g_bad_width
    $error("bmask_ram: DATA_W must be 16, 18, 32 or 36");
  end

  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] merged_word;

  assign lane_we = be_i & {LANES{we_i}};

  bmr_array #(
    .ADDR_W   (ADDR_W),
    .LANE_W   (LANE_W),
    .LANES    (LANES),
    .INIT_ONES(INIT_ONES)
  ) u_array (
    .clk_i    (clk_i),
    .addr_i   (addr_i),
    .lane_we_i(lane_we),
    .wdata_i  (wdata_i),
    .rword_o  (old_word)
  );

  bmr_merge #(
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) u_merge (
    .old_i   (old_word),
    .new_i   (wdata_i),
    .sel_i   (lane_we),
    .merged_o(merged_word)
  );

  bmr_rd_reg #(
    .DATA_W(DATA_W)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .re_i    (re_i),
    .merged_i(merged_word),
    .old_i   (old_word),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/bmr_chk.sv
module bmr_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [LANES-1:0]  be_i,
  input logic [DATA_W-1:0] rdata_o
);
  AST_RST_ZERO: assert property (@(posedge clk_i) !rst_ni |-> rdata_o == '0); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && !re_i |=> $stable(rdata_o)); // R8

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_WR_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && be_i[l] |=> rdata_o[l*LANE_W +: LANE_W] == $past(wdata_i[l*LANE_W +: LANE_W])); // R2

    AST_RD_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && be_i[l] ##1 (re_i && !we_i && addr_i == $past(addr_i))
      |=> rdata_o[l*LANE_W +: LANE_W] == $past(wdata_i[l*LANE_W +: LANE_W], 2)); // R7
  end
endmodule

bind bmask_ram bmr_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .LANE_W(LANE_W),
  .LANES (LANES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .re_i   (re_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .be_i   (be_i),
  .rdata_o(rdata_o)
);

// File: tb/bmask_ram_tb_top.sv
`timescale 1ns/1ps
module bmask_ram_tb_top;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we, re;
  logic [AW-1:0] addr;
  logic [1:0]    be16;
  logic [15:0]   wd16;
  logic [15:0]   rd16;
  logic [3:0]    be36;
  logic [35:0]   wd36;
  logic [35:0]   rd36;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  bmask_ram #(.DATA_W(16), .ADDR_W(AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wd16), .be_i(be16), .rdata_o(rd16)
  );

  bmask_ram #(.DATA_W(36), .ADDR_W(AW)) dut36_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wd36), .be_i(be36), .rdata_o(rd36)
  );

  typedef struct packed {
    logic          we;
    logic          re;
    logic [AW-1:0] addr;
    logic [1:0]    be;
    logic [15:0]   wd;
    logic [15:0]   exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 6'd0, 2'b10, 16'hABCD, 16'hABFF, 4'd6},  // R6 R3 upper lane
    '{1'b1, 1'b0, 6'd1, 2'b01, 16'hABCD, 16'hFFCD, 4'd6},  // R6 R3 lower lane
    '{1'b1, 1'b0, 6'd2, 2'b11, 16'hABCD, 16'hABCD, 4'd6},  // R6 both lanes
    '{1'b0, 1'b1, 6'd0, 2'b00, 16'h0000, 16'hABFF, 4'd2},  // R2 kept lane
    '{1'b0, 1'b1, 6'd1, 2'b00, 16'h0000, 16'hFFCD, 4'd2},  // R2
    '{1'b0, 1'b1, 6'd2, 2'b00, 16'h0000, 16'hABCD, 4'd7},  // R7
    '{1'b0, 1'b0, 6'd1, 2'b11, 16'h1111, 16'hABCD, 4'd8},  // R8 hold
    '{1'b1, 1'b0, 6'd0, 2'b00, 16'h1234, 16'hABFF, 4'd5},  // R5 empty mask
    '{1'b0, 1'b1, 6'd0, 2'b00, 16'h0000, 16'hABFF, 4'd5},  // R5 readback
    '{1'b1, 1'b1, 6'd3, 2'b01, 16'h5566, 16'hFF66, 4'd11}, // R11 collision
    '{1'b0, 1'b1, 6'd3, 2'b00, 16'h0000, 16'hFF66, 4'd11}, // R11 readback
    '{1'b0, 1'b1, 6'd5, 2'b00, 16'h0000, 16'hFFFF, 4'd10}, // R10 background
    '{1'b0, 1'b0, 6'd2, 2'b11, 16'h0000, 16'hFFFF, 4'd1},  // R1 no write
    '{1'b0, 1'b1, 6'd2, 2'b00, 16'h0000, 16'hABCD, 4'd1}   // R1 readback
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs change at a negedge; result sampled at the following negedge
  task automatic cyc(input logic w, input logic r, input logic [AW-1:0] a,
                     input logic [1:0] b16, input logic [15:0] d16,
                     input logic [3:0] b36, input logic [35:0] d36);
    we = w; re = r; addr = a; be16 = b16; wd16 = d16; be36 = b36; wd36 = d36;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(100_000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic [35:0] d36a, d36b, e36;
    we = 0; re = 0; addr = '0; be16 = '0; wd16 = '0; be36 = '0; wd36 = '0;
    repeat (3) @(negedge clk_i);
    chk("R9 reset 16", {20'h0, rd16}, 36'h0);
    chk("R9 reset 36", rd36, 36'h0);
    rst_ni = 1'b1;

    // 16-bit table; 36-bit copy sees an empty mask so stays at background
    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].we, TBL[i].re, TBL[i].addr, TBL[i].be, TBL[i].wd, 4'b0000, 36'h0);
      chk($sformatf("R%0d row %0d", TBL[i].req, i), {20'h0, rd16}, {20'h0, TBL[i].exp});
      chk($sformatf("R5 R10 row %0d dut36", i), rd36, 36'hF_FFFF_FFFF);
    end

    // R4 R3: 9-bit lanes, alternate lanes
    d36a = 36'h1_2345_6789;
    e36  = {9'h1FF, d36a[26:18], 9'h1FF, d36a[8:0]};
    cyc(1, 0, 6'd10, 2'b00, 16'h0, 4'b0101, d36a);
    chk("R4 lanes 0,2 write", rd36, e36);
    cyc(0, 1, 6'd10, 2'b00, 16'h0, 4'b0000, 36'h0);
    chk("R4 lanes 0,2 readback", rd36, e36);

    // R3: top lane only, with a read in the same cycle (R11)
    d36b = 36'hA_BCDE_F012;
    e36  = {d36b[35:27], e36[26:0]};
    cyc(1, 1, 6'd10, 2'b00, 16'h0, 4'b1000, d36b);
    chk("R3 R11 top lane write", rd36, e36);
    cyc(0, 0, 6'd11, 2'b00, 16'h0, 4'b1111, 36'h0);
    chk("R8 hold 36", rd36, e36);
    cyc(0, 1, 6'd10, 2'b00, 16'h0, 4'b0000, 36'h0);
    chk("R3 top lane readback", rd36, e36);

    // R9: reset mid-run clears output, keeps contents
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R9 mid reset 36", rd36, 36'h0);
    chk("R9 mid reset 16", {20'h0, rd16}, 36'h0);
    rst_ni = 1'b1;
    cyc(0, 1, 6'd10, 2'b00, 16'h0, 4'b0000, 36'h0);
    chk("R9 contents kept 36", rd36, e36);
    cyc(0, 1, 6'd0, 2'b00, 16'h0, 4'b0000, 36'h0);
    chk("R9 contents kept 16", {20'h0, rd16}, {20'h0, 16'hABFF});

    finish_run();
  end
endmodule